// File: doc/BRIEF.md
# Byte FIFO Pair with Interrupt Status Controller

This block sits between a register interface and a serial bus engine. It holds one byte queue in each direction: a transmit queue that the register side fills and the engine drains, and a receive queue that the engine fills and the register side drains. Each queue has its own enable and its own programmable trigger level. A transmit level at or below its trigger asks for more data. A receive level at or above its trigger asks for the data to be drained. A receive fill that stays below its trigger is reported by a trailing timer once it has waited for a programmable number of cycles.

The block merges the queue conditions with five transfer event pulses from the engine into one twelve-bit status register. Each bit is cleared by writing a one to it. A single interrupt line is high while any status bit is set and its enable bit is also set. A 32-bit status word reports the fill level, full flag and empty flag of both queues.

All four data paths use valid/ready. A consumer may assert ready at any time. If it pops while valid is low, it receives zero and an underrun is recorded. A producer that offers a byte while ready is low does not get back-pressure. Its byte is discarded and an overrun is recorded when the queue is enabled. Upstream logic that must not lose data therefore waits for ready before asserting valid.

Top module: `fq_top`

## Requirements
- R1: Bytes leave each queue in the order they were accepted. A byte is accepted on a clock edge where valid and ready are both high. A byte is removed on an edge where the output valid and ready are both high. Each accepted push with no pop in the same cycle raises the level by one on that edge.
- R2: The status word reports the levels and flags in these fields. Bits [6:0] hold the transmit level, bit 7 the transmit full flag and bit 8 the transmit empty flag. Bits [22:16] hold the receive level, bit 23 the receive full flag and bit 24 the receive empty flag. All other bits read zero. The level never exceeds DEPTH.
- R3: A push offered while the enabled queue is full is discarded and leaves the level unchanged. On that same edge it sets status bit 3 for the transmit queue or bit 5 for the receive queue.
- R4: A pop requested while an enabled queue is empty presents zero on the data output. On that same edge it sets status bit 2 for the transmit queue or bit 4 for the receive queue.
- R5: Status bit 0 is set on every edge after a cycle in which the transmit queue is enabled and its level is at or below the transmit trigger. Status bit 1 is set the same way while the receive queue is enabled and its level is at or above the receive trigger. A clear does not remove either bit while its condition still holds.
- R6: The trailing timer restarts on every accepted receive push. It counts only while the receive queue is not empty and is below its trigger. After a push, status bit 6 is set on the edge trail_limit+1 cycles later, and only once per push.
- R7: A one on xfer_evt bit k sets status bit 7+k on the next edge. The bits are done (7), abort (8), no acknowledge (9), no device (10) and timeout (11).
- R8: A cycle with clr_valid high clears every status bit whose clr_mask bit is one. If a bit is being set in the same cycle, the set wins.
- R9: irq is high exactly while some status bit is set together with the int_en bit at the same position.
- R10: While a queue's enable bit is clear, the queue is emptied and both its ready and valid are low. It reports empty, it records neither overrun nor underrun, and it does not set its trigger status bit.
- R11: The control word has these fields. Bit 0 enables the receive queue, bit 1 enables the transmit queue, bits [10:4] hold the receive trigger and bits [22:16] hold the transmit trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_ctrl | input | 32 | Queue enables and trigger levels (R11) |
| trail_limit | input | 4 | Trailing wait, in cycles after a receive push, minus one |
| int_en | input | 12 | Interrupt enable per status bit |
| tx_in_valid | input | 1 | Register side offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue enabled and not full |
| tx_in_data | input | DW | Transmit byte in |
| tx_out_valid | output | 1 | Transmit queue holds a byte |
| tx_out_ready | input | 1 | Engine pops a transmit byte |
| tx_out_data | output | DW | Head transmit byte, zero when empty |
| rx_in_valid | input | 1 | Engine offers a received byte |
| rx_in_ready | output | 1 | Receive queue enabled and not full |
| rx_in_data | input | DW | Received byte in |
| rx_out_valid | output | 1 | Receive queue holds a byte |
| rx_out_ready | input | 1 | Register side pops a received byte |
| rx_out_data | output | DW | Head received byte, zero when empty |
| xfer_evt | input | 5 | Transfer event pulses: done, abort, no-ack, no-device, timeout |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 12 | Status bits to clear |
| int_status | output | 12 | Interrupt status register |
| irq | output | 1 | Interrupt request |
| fifo_stat | output | 32 | Level and flag word (R2) |

## Verification
The bench fills the transmit queue to exactly DEPTH and then offers one more byte. A design that wraps its pointer at that point would corrupt the queue order or show a level of zero. The bench also drains each queue past empty. A design that presents stale data there, or misses the underrun, is caught on the data port and in the status register. The trailing timer is probed one cycle before and at its expected edge, with a restarting push in between. This exposes off-by-one counts and timers that ignore restarts. The bench also covers a clear that coincides with a new event, a level condition that still holds during a clear, and a disabled queue. A design where clear wins, or where a disabled queue still raises its almost-empty request, therefore shows a wrong status bit.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int IRQ_N   = 12;
  localparam int EVT_N   = 5;
  localparam int TRIG_W  = 7;
  // control word fields
  localparam int CTL_RX_EN   = 0;
  localparam int CTL_TX_EN   = 1;
  localparam int CTL_RXT_LSB = 4;
  localparam int CTL_TXT_LSB = 16;
  // status bit positions
  localparam int ST_TX_AE   = 0;
  localparam int ST_RX_AF   = 1;
  localparam int ST_TX_UDR  = 2;
  localparam int ST_TX_OVR  = 3;
  localparam int ST_RX_UDR  = 4;
  localparam int ST_RX_OVR  = 5;
  localparam int ST_TRAIL   = 6;
  localparam int ST_EVT_LSB = 7;

  typedef struct packed {
    logic              empty;
    logic              full;
    logic [TRIG_W-1:0] level;
  } q_view_t;

  function automatic logic [31:0] pack_stat(q_view_t tx, q_view_t rx);
    logic [31:0] w;
    w = '0;
    w[8:0]   = tx;
    w[24:16] = rx;
    return w;
  endfunction
endpackage

// File: rtl/fq_byte_fifo.sv
module fq_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovr,
  output logic          udr
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic          acc_push, acc_pop;

  assign full       = (count == LW'(DEPTH));
  assign empty      = (count == '0);
  assign push_ready = en && !full;
  assign pop_valid  = en && !empty;
  assign acc_push   = push && push_ready;
  assign acc_pop    = pop && pop_valid;
  assign ovr        = en && push && full;
  assign udr        = en && pop && empty;
  assign level      = count;
  assign pop_data   = pop_valid ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (acc_push) wr_ptr <= wr_ptr + 1'b1;
      if (acc_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({acc_push, acc_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acc_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/fq_trail_timer.sv
module fq_trail_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;
  logic          armed;

  assign fire = armed && run && !restart && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (fire) begin
      armed <= 1'b0;
    end else if (armed && run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fq_irq_status.sv
module fq_irq_status #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_valid,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_valid ? clr_mask : '0;
  assign irq     = |(status & en);

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | set_vec;
  end
endmodule

// File: rtl/fq_top.sv
module fq_top
  import fq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      fifo_ctrl,
  input  logic [3:0]       trail_limit,
  input  logic [IRQ_N-1:0] int_en,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [DW-1:0]    tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [DW-1:0]    tx_out_data,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [DW-1:0]    rx_in_data,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [DW-1:0]    rx_out_data,
  input  logic [EVT_N-1:0] xfer_evt,
  input  logic             clr_valid,
  input  logic [IRQ_N-1:0] clr_mask,
  output logic [IRQ_N-1:0] int_status,
  output logic             irq,
  output logic [31:0]      fifo_stat
);
  logic              rx_en, tx_en;
  logic [TRIG_W-1:0] rx_trig, tx_trig;
  logic [LW-1:0]     tx_lvl, rx_lvl;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovr, tx_udr, rx_ovr, rx_udr;
  logic              rx_below, trail_fire;
  logic [IRQ_N-1:0]  set_vec;
  q_view_t           tx_view, rx_view;
  logic              ctrl_unused;

  // R11 control field decode
  assign rx_en   = fifo_ctrl[CTL_RX_EN];
  assign tx_en   = fifo_ctrl[CTL_TX_EN];
  assign rx_trig = fifo_ctrl[CTL_RXT_LSB +: TRIG_W];
  assign tx_trig = fifo_ctrl[CTL_TXT_LSB +: TRIG_W];
  assign ctrl_unused = ^{fifo_ctrl[31:23], fifo_ctrl[15:11], fifo_ctrl[3:2]};

  fq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(tx_en),
    .push(tx_in_valid), .push_data(tx_in_data), .push_ready(tx_in_ready),
    .pop(tx_out_ready), .pop_valid(tx_out_valid), .pop_data(tx_out_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty), .ovr(tx_ovr), .udr(tx_udr)
  );

  fq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(rx_en),
    .push(rx_in_valid), .push_data(rx_in_data), .push_ready(rx_in_ready),
    .pop(rx_out_ready), .pop_valid(rx_out_valid), .pop_data(rx_out_data),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty), .ovr(rx_ovr), .udr(rx_udr)
  );

  assign rx_below = TRIG_W'(rx_lvl) < rx_trig;

  fq_trail_timer #(.CW(4)) u_trail (
    .clk(clk), .rst_n(rst_n),
    .restart(rx_in_valid && rx_in_ready),
    .run(!rx_empty && rx_below),
    .limit(trail_limit),
    .fire(trail_fire)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[ST_TX_AE]   = tx_en && (TRIG_W'(tx_lvl) <= tx_trig);
    set_vec[ST_RX_AF]   = rx_en && !rx_below;
    set_vec[ST_TX_UDR]  = tx_udr;
    set_vec[ST_TX_OVR]  = tx_ovr;
    set_vec[ST_RX_UDR]  = rx_udr;
    set_vec[ST_RX_OVR]  = rx_ovr;
    set_vec[ST_TRAIL]   = trail_fire;
    set_vec[ST_EVT_LSB +: EVT_N] = xfer_evt;
  end

  fq_irq_status #(.N(IRQ_N)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .en(int_en),
    .status(int_status), .irq(irq)
  );

  assign tx_view   = '{empty: tx_empty, full: tx_full, level: TRIG_W'(tx_lvl)};
  assign rx_view   = '{empty: rx_empty, full: rx_full, level: TRIG_W'(rx_lvl)};
  assign fifo_stat = pack_stat(tx_view, rx_view);
endmodule

// File: rtl/fq_top_chk.sv
module fq_top_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [22:0] fifo_ctrl,
  input logic        tx_in_valid,
  input logic        tx_in_ready,
  input logic        tx_out_valid,
  input logic        tx_out_ready,
  input logic [7:0]  tx_out_data,
  input logic [4:0]  xfer_evt,
  input logic        clr_valid,
  input logic [11:0] clr_mask,
  input logic [11:0] int_status,
  input logic [6:0]  tx_lvl
);
  // R1
  tx_push_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && !tx_out_ready) |=> (tx_lvl == $past(tx_lvl) + 7'd1));
  // R2
  tx_lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= 7'(DEPTH));
  // R3
  tx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ctrl[1] && tx_in_valid && !tx_in_ready) |=> int_status[3]);
  // R4
  tx_udr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_ready && !tx_out_valid) |-> (tx_out_data == 8'h00));
  // R5
  tx_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ctrl[1] && (tx_lvl <= fifo_ctrl[22:16])) |=> int_status[0]);
  // R7
  evt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt[0] |=> int_status[7]);
  // R8
  w1c_nodev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mask[10] && !xfer_evt[3]) |=> !int_status[10]);
  // R10
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_ctrl[1] |-> (!tx_in_ready && !tx_out_valid));
endmodule

bind fq_top fq_top_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_ctrl(fifo_ctrl[22:0]),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data[7:0]), .xfer_evt(xfer_evt),
  .clr_valid(clr_valid), .clr_mask(clr_mask), .int_status(int_status),
  .tx_lvl(fifo_stat[6:0])
);

// File: tb/tb_fq_top.sv
`timescale 1ns/1ps
module tb_fq_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fifo_ctrl = '0;
  logic [3:0]  trail_limit = '0;
  logic [11:0] int_en = '0;
  logic        tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic        rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0]  tx_in_data = '0, rx_in_data = '0;
  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0]  tx_out_data, rx_out_data;
  logic [4:0]  xfer_evt = '0;
  logic        clr_valid = 1'b0;
  logic [11:0] clr_mask = '0;
  logic [11:0] int_status;
  logic        irq;
  logic [31:0] fifo_stat;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_q[$], rx_q[$];

  always #2 clk = ~clk;

  fq_top #(.DEPTH(DEPTH), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_ctrl(fifo_ctrl), .trail_limit(trail_limit),
    .int_en(int_en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .xfer_evt(xfer_evt), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .int_status(int_status), .irq(irq), .fifo_stat(fifo_stat)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitors: compare popped bytes against the scoreboard queues (R1)
  always @(negedge clk) begin
    #1;
    if (tx_out_valid && tx_out_ready) begin
      if (tx_q.size() == 0) check("R1 tx unexpected byte", {24'h0, tx_out_data}, 32'hxx);
      else check("R1 tx order", {24'h0, tx_out_data}, {24'h0, tx_q.pop_front()});
    end
    if (rx_out_valid && rx_out_ready) begin
      if (rx_q.size() == 0) check("R1 rx unexpected byte", {24'h0, rx_out_data}, 32'hxx);
      else check("R1 rx order", {24'h0, rx_out_data}, {24'h0, rx_q.pop_front()});
    end
  end

  // drivers: called at a negedge, return at the negedge after the edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push_tx(logic [7:0] b, bit accept);
    tx_in_valid = 1'b1; tx_in_data = b;
    if (accept) tx_q.push_back(b);
    step();
    tx_in_valid = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b, bit accept);
    rx_in_valid = 1'b1; rx_in_data = b;
    if (accept) rx_q.push_back(b);
    step();
    rx_in_valid = 1'b0;
  endtask

  task automatic pop_tx(int n);
    tx_out_ready = 1'b1;
    repeat (n) step();
    tx_out_ready = 1'b0;
  endtask

  task automatic pop_rx(int n);
    rx_out_ready = 1'b1;
    repeat (n) step();
    rx_out_ready = 1'b0;
  endtask

  task automatic clear(logic [11:0] m);
    clr_valid = 1'b1; clr_mask = m;
    step();
    clr_valid = 1'b0; clr_mask = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    // reset state: disabled queues report empty (R2, R10)
    check("R8 reset status", {20'h0, int_status}, 32'h0);
    check("R9 reset irq", {31'h0, irq}, 32'h0);
    check("R2 R10 reset stat word", fifo_stat, 32'h0100_0100);
    check("R10 disabled tx ready", {31'h0, tx_in_ready}, 32'h0);

    // R11: rx en bit0, tx en bit1, rx trig [10:4]=4, tx trig [22:16]=4
    fifo_ctrl = 32'h0004_0043;
    trail_limit = 4'd5;
    step(); step();
    check("R5 tx almost empty", {31'h0, int_status[0]}, 32'h1);
    clear(12'hfff);
    check("R5 R8 held condition survives clear", {20'h0, int_status}, 32'h001);

    for (int i = 0; i < DEPTH; i++) push_tx(8'hA0 + 8'(i), 1'b1);
    check("R2 tx full level", {23'h0, fifo_stat[8:0]}, 32'h090);
    clear(12'hfff);
    check("R5 R8 cleared once condition gone", {20'h0, int_status}, 32'h0);
    push_tx(8'h55, 1'b0);
    check("R3 tx overrun bit", {31'h0, int_status[3]}, 32'h1);
    check("R3 tx level kept", {25'h0, fifo_stat[6:0]}, DEPTH);
    pop_tx(DEPTH);
    check("R1 tx scoreboard drained", tx_q.size(), 0);
    check("R4 tx empty data zero", {24'h0, tx_out_data}, 32'h0);
    pop_tx(1);
    check("R4 tx underrun bit", {31'h0, int_status[2]}, 32'h1);

    // trailing timer with a restart in between (R6)
    clear(12'hfff);
    push_rx(8'h11, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 no trailing before restart", {31'h0, int_status[6]}, 32'h0);
    push_rx(8'h22, 1'b1);
    push_rx(8'h33, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R6 trailing one cycle early", {31'h0, int_status[6]}, 32'h0);
    step();
    check("R6 trailing on time", {31'h0, int_status[6]}, 32'h1);
    check("R2 rx level and empty", {23'h0, fifo_stat[24:16]}, 32'h003);
    push_rx(8'h44, 1'b1);
    step();
    check("R5 R11 rx almost full", {31'h0, int_status[1]}, 32'h1);
    pop_rx(4);
    check("R4 rx empty data zero", {24'h0, rx_out_data}, 32'h0);
    pop_rx(1);
    check("R4 rx underrun bit", {31'h0, int_status[4]}, 32'h1);
    for (int i = 0; i < DEPTH; i++) push_rx(8'h60 + 8'(i), 1'b1);
    push_rx(8'hEE, 1'b0);
    check("R3 rx overrun bit", {31'h0, int_status[5]}, 32'h1);
    check("R2 rx full flag", {31'h0, fifo_stat[23]}, 32'h1);
    pop_rx(DEPTH);
    check("R1 rx scoreboard drained", rx_q.size(), 0);

    // events, irq, write-one-to-clear (R7, R8, R9)
    clear(12'hfff);
    int_en = 12'h200;
    xfer_evt = 5'b00100;
    step();
    xfer_evt = '0;
    check("R7 no-ack bit", {31'h0, int_status[9]}, 32'h1);
    check("R9 irq on enabled bit", {31'h0, irq}, 32'h1);
    xfer_evt = 5'b10001;
    step();
    xfer_evt = '0;
    check("R7 done and timeout bits", {27'h0, int_status[11:7]}, 32'h15);
    clear(12'h200);
    check("R8 selective clear", {27'h0, int_status[11:7]}, 32'h11);
    check("R9 irq drops with only masked bits", {31'h0, irq}, 32'h0);
    xfer_evt = 5'b00010;
    clr_valid = 1'b1; clr_mask = 12'h100;
    step();
    xfer_evt = '0; clr_valid = 1'b0; clr_mask = '0;
    check("R8 set wins over clear", {31'h0, int_status[8]}, 32'h1);

    // disabled transmit queue (R10)
    fifo_ctrl = 32'h0004_0041;
    step();
    clear(12'hfff);
    check("R10 disabled tx ready low", {31'h0, tx_in_ready}, 32'h0);
    push_tx(8'h77, 1'b0);
    pop_tx(1);
    step();
    check("R10 no tx flags while disabled", {28'h0, int_status[3:0] & 4'b1101}, 32'h0);
    check("R10 disabled tx stat", {23'h0, fifo_stat[8:0]}, 32'h100);

    finish_run();
  end
endmodule